// File: doc/BRIEF.md
# Working Register Bank with Pointer Pairs

This block is the general-purpose register storage of a small 8-bit processor core. It holds thirty-two byte-wide registers. Two byte reads and one 16-bit read are served combinationally in the same cycle. One write port stores either a single byte or an aligned register pair on a clock edge. The last six registers double as three 16-bit address pointers. A pointer port forms an effective data address from a selected pointer. It can post-increment or pre-decrement the pointer in place, or add a short unsigned offset without changing the pointer.

The register bank also appears at the bottom of the data address map. An effective address below 0x20 names a register, so an indirect load returns that register and an indirect store writes it. Addresses 0x20 through 0x5F are flagged as the I/O window. Decode, arithmetic and the data memory sit outside this block. The core combines the region flags with its own memory path.

Top module: `work_reg_bank`

## Requirements
- R1: While `rstN` is low and after it returns high, every register reads as 0x00.
- R2: `rdDataA` and `rdDataB` show the registers addressed by `rdAddrA` and `rdAddrB` in the same cycle, with no clock edge needed.
- R3: When `wrEn`=1 and `wrWide`=0, `wrData[7:0]` is stored into register `wrAddr` at the rising clock edge.
- R4: When `wrEn`=1 and `wrWide`=1, register 2*`wrAddr[4:1]` takes `wrData[7:0]` and register 2*`wrAddr[4:1]`+1 takes `wrData[15:8]` on the same edge. `wrAddr[0]` is ignored.
- R5: `rdPairData` equals {register 2*`rdPairIdx`+1, register 2*`rdPairIdx`}.
- R6: A read in the same cycle as a write to the same register returns the value held before the edge.
- R7: `ptrSel` 0, 1 and 2 select the pointers held in registers 26/27, 28/29 and 30/31, with the low byte in the even register. `ptrSel`=3 selects nothing: `effAddr` is 0, both region flags are 0, and no register changes.
- R8: `ptrMode`=1 (post-increment) gives `effAddr` = pointer, and with `ptrEn`=1 the pointer becomes pointer+1 modulo 2^16.
- R9: `ptrMode`=2 (pre-decrement) gives `effAddr` = pointer-1 modulo 2^16, and with `ptrEn`=1 the pointer takes that value.
- R10: `ptrMode`=0 gives `effAddr` = pointer, and `ptrMode`=3 gives pointer + zero-extended `ptrDisp`. Neither mode changes the pointer.
- R11: `effIsReg` is 1 for `effAddr` < 0x20 and `effIsIo` is 1 for 0x20 <= `effAddr` <= 0x5F. When `effIsReg` is 1, `ptrLoadData` shows register `effAddr[4:0]` (otherwise 0x00). With `ptrEn`=1 and `ptrStore`=1, `ptrStoreData` is written to that register.
- R12: When several writes hit one register on the same edge, the pointer update wins over the write port, and the write port wins over an indirect store.
- R13: A register that no write source addresses keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddrA | input | 5 | Byte read port A register index |
| rdAddrB | input | 5 | Byte read port B register index |
| rdDataA | output | 8 | Byte read port A data |
| rdDataB | output | 8 | Byte read port B data |
| rdPairIdx | input | 4 | Pair index for the 16-bit read |
| rdPairData | output | 16 | 16-bit read data {odd, even} |
| wrEn | input | 1 | Write port enable |
| wrWide | input | 1 | 1 = pair write, 0 = byte write |
| wrAddr | input | 5 | Write register index |
| wrData | input | 16 | Write data (byte writes use bits 7:0) |
| ptrEn | input | 1 | Pointer access enable |
| ptrSel | input | 2 | Pointer select |
| ptrMode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 offset |
| ptrDisp | input | 6 | Unsigned offset for mode 3 |
| ptrStore | input | 1 | Indirect store request |
| ptrStoreData | input | 8 | Indirect store data |
| effAddr | output | 16 | Effective data address |
| effIsReg | output | 1 | Effective address falls on a register |
| effIsIo | output | 1 | Effective address falls in the I/O window |
| ptrLoadData | output | 8 | Register value at the effective address |

## Verification
The bench builds the block with its default parameters: a 6-bit offset and a 64-byte I/O window above the 32 registers. With these values both pointer wrap-arounds (0xFFFF to 0x0000 and back) can be reached with single operations. The region edges at 0x1F/0x20 and 0x5F/0x60 are also one small offset or decrement away from pointer values the bench loads through the pair write. Collisions between a pointer update, the write port and an indirect store on the same register are likewise reachable in a single cycle.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  parameter int NUM_REGS = 32;
  parameter int BYTE_W   = 8;
  parameter int NUM_PTRS = 3;
  parameter int PTR_W    = 2 * BYTE_W;
  parameter int REG_AW   = $clog2(NUM_REGS);
  parameter int PAIR_AW  = REG_AW - 1;
  parameter int PSEL_W   = 2;
  parameter int PTR_BASE = NUM_REGS - 2 * NUM_PTRS;

  typedef enum logic [1:0] {
    PM_PLAIN   = 2'd0,
    PM_POSTINC = 2'd1,
    PM_PREDEC  = 2'd2,
    PM_OFFSET  = 2'd3
  } ptr_mode_e;

  typedef struct packed {
    logic              loEn;
    logic [REG_AW-1:0] loIdx;
    logic [BYTE_W-1:0] loData;
    logic              hiEn;
    logic [REG_AW-1:0] hiIdx;
    logic [BYTE_W-1:0] hiData;
    logic              stEn;
    logic [REG_AW-1:0] stIdx;
    logic [BYTE_W-1:0] stData;
    logic              pUpd;
    logic [REG_AW-1:0] pLoIdx;
    logic [PTR_W-1:0]  pNext;
  } wrb_strobe_t;
endpackage

// File: rtl/wrb_ctrl.sv
module wrb_ctrl
  import wrb_pkg::*;
#(
  parameter int DISP_W  = 6,
  parameter int IO_SPAN = 64
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic                            wrWide,
  input  logic [REG_AW-1:0]               wrAddr,
  input  logic [PTR_W-1:0]                wrData,
  input  logic                            ptrEn,
  input  logic [PSEL_W-1:0]               ptrSel,
  input  logic [1:0]                      ptrMode,
  input  logic [DISP_W-1:0]               ptrDisp,
  input  logic                            ptrStore,
  input  logic [BYTE_W-1:0]               ptrStoreData,
  input  logic [NUM_PTRS-1:0][PTR_W-1:0]  ptrVals,
  output wrb_strobe_t                     strobe,
  output logic [PTR_W-1:0]                effAddr,
  output logic                            effIsReg,
  output logic                            effIsIo
);
  localparam int IO_END = NUM_REGS + IO_SPAN;

  ptr_mode_e        mode;
  logic             selOk;
  logic [PTR_W-1:0] curPtr;
  logic [PTR_W-1:0] dispExt;

  assign mode    = ptr_mode_e'(ptrMode);
  assign selOk   = (int'(ptrSel) < NUM_PTRS);
  assign dispExt = {{(PTR_W-DISP_W){1'b0}}, ptrDisp};

  always_comb begin
    curPtr = '0;
    for (int p = 0; p < NUM_PTRS; p++) begin
      if (int'(ptrSel) == p) curPtr = ptrVals[p];
    end
  end

  always_comb begin
    effAddr = '0;
    if (selOk) begin
      unique case (mode)
        PM_PREDEC: effAddr = curPtr - 1'b1;
        PM_OFFSET: effAddr = curPtr + dispExt;
        default:   effAddr = curPtr;
      endcase
    end
  end

  assign effIsReg = selOk && (int'(effAddr) < NUM_REGS);
  assign effIsIo  = selOk && (int'(effAddr) >= NUM_REGS) && (int'(effAddr) < IO_END);

  always_comb begin
    strobe        = '0;
    strobe.loEn   = wrEn;
    strobe.loIdx  = wrWide ? {wrAddr[REG_AW-1:1], 1'b0} : wrAddr;
    strobe.loData = wrData[BYTE_W-1:0];
    strobe.hiEn   = wrEn && wrWide;
    strobe.hiIdx  = {wrAddr[REG_AW-1:1], 1'b1};
    strobe.hiData = wrData[PTR_W-1:BYTE_W];
    strobe.stEn   = ptrEn && ptrStore && effIsReg;
    strobe.stIdx  = effAddr[REG_AW-1:0];
    strobe.stData = ptrStoreData;
    strobe.pUpd   = ptrEn && selOk && (mode == PM_POSTINC || mode == PM_PREDEC);
    strobe.pLoIdx = REG_AW'(PTR_BASE + 2 * int'(ptrSel));
    strobe.pNext  = (mode == PM_POSTINC) ? curPtr + 1'b1 : curPtr - 1'b1;
  end

  // R8: post-increment advances the selected pointer by one
  a_r8_postinc: assert property (@(posedge clk) disable iff (!rstN)
    (ptrEn && selOk && mode == PM_POSTINC) |=>
      ptrVals[$past(ptrSel)] == $past(effAddr) + 1'b1);

  // R9: pre-decrement leaves the pointer equal to the address it produced
  a_r9_predec: assert property (@(posedge clk) disable iff (!rstN)
    (ptrEn && selOk && mode == PM_PREDEC) |=>
      ptrVals[$past(ptrSel)] == $past(effAddr));

  // R11: register region and I/O window never overlap
  a_r11_region: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({effIsReg, effIsIo}));
endmodule

// File: rtl/wrb_datapath.sv
module wrb_datapath
  import wrb_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  wrb_strobe_t                     strobe,
  input  logic [REG_AW-1:0]               rdAddrA,
  input  logic [REG_AW-1:0]               rdAddrB,
  input  logic [PAIR_AW-1:0]              rdPairIdx,
  input  logic [REG_AW-1:0]               ldIdx,
  output logic [BYTE_W-1:0]               rdDataA,
  output logic [BYTE_W-1:0]               rdDataB,
  output logic [PTR_W-1:0]                rdPairData,
  output logic [BYTE_W-1:0]               ldData,
  output logic [NUM_PTRS-1:0][PTR_W-1:0]  ptrVals
);
  logic [BYTE_W-1:0] regs [NUM_REGS];
  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [REG_AW-1:0] IDX = REG_AW'(i);
    logic pLo, pHi;
    assign pLo = strobe.pUpd && (strobe.pLoIdx == IDX);
    assign pHi = strobe.pUpd && ((strobe.pLoIdx | REG_AW'(1)) == IDX);
    assign hit[i] = (strobe.stEn && strobe.stIdx == IDX) ||
                    (strobe.loEn && strobe.loIdx == IDX) ||
                    (strobe.hiEn && strobe.hiIdx == IDX) || pLo || pHi;

    // lowest priority first; later assignments take precedence (R12)
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regs[i] <= '0;
      end else begin
        if (strobe.stEn && strobe.stIdx == IDX) regs[i] <= strobe.stData;
        if (strobe.loEn && strobe.loIdx == IDX) regs[i] <= strobe.loData;
        if (strobe.hiEn && strobe.hiIdx == IDX) regs[i] <= strobe.hiData;
        if (pLo) regs[i] <= strobe.pNext[BYTE_W-1:0];
        if (pHi) regs[i] <= strobe.pNext[PTR_W-1:BYTE_W];
      end
    end

    // R13: untouched registers keep their contents
    a_r13_hold: assert property (@(posedge clk) disable iff (!rstN)
      !hit[i] |=> $stable(regs[i]));
  end

  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptr
    assign ptrVals[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
  end

  assign rdDataA    = regs[rdAddrA];
  assign rdDataB    = regs[rdAddrB];
  assign rdPairData = {regs[{rdPairIdx, 1'b1}], regs[{rdPairIdx, 1'b0}]};
  assign ldData     = regs[ldIdx];
endmodule

// File: rtl/work_reg_bank.sv
module work_reg_bank
  import wrb_pkg::*;
#(
  parameter int DISP_W  = 6,
  parameter int IO_SPAN = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  rdAddrA,
  input  logic [4:0]  rdAddrB,
  output logic [7:0]  rdDataA,
  output logic [7:0]  rdDataB,
  input  logic [3:0]  rdPairIdx,
  output logic [15:0] rdPairData,
  input  logic        wrEn,
  input  logic        wrWide,
  input  logic [4:0]  wrAddr,
  input  logic [15:0] wrData,
  input  logic        ptrEn,
  input  logic [1:0]  ptrSel,
  input  logic [1:0]  ptrMode,
  input  logic [DISP_W-1:0] ptrDisp,
  input  logic        ptrStore,
  input  logic [7:0]  ptrStoreData,
  output logic [15:0] effAddr,
  output logic        effIsReg,
  output logic        effIsIo,
  output logic [7:0]  ptrLoadData
);
  wrb_strobe_t strobe;
  logic [NUM_PTRS-1:0][PTR_W-1:0] ptrVals;
  logic [BYTE_W-1:0] ldData;

  wrb_ctrl #(.DISP_W(DISP_W), .IO_SPAN(IO_SPAN)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrWide(wrWide), .wrAddr(wrAddr), .wrData(wrData),
    .ptrEn(ptrEn), .ptrSel(ptrSel), .ptrMode(ptrMode), .ptrDisp(ptrDisp),
    .ptrStore(ptrStore), .ptrStoreData(ptrStoreData), .ptrVals(ptrVals),
    .strobe(strobe), .effAddr(effAddr), .effIsReg(effIsReg), .effIsIo(effIsIo)
  );

  wrb_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdPairIdx(rdPairIdx),
    .ldIdx(effAddr[REG_AW-1:0]),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .rdPairData(rdPairData),
    .ldData(ldData), .ptrVals(ptrVals)
  );

  assign ptrLoadData = effIsReg ? ldData : '0;
endmodule

// File: tb/test_work_reg_bank.sv
module test_work_reg_bank;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic [4:0] rdAddrA = 0, rdAddrB = 0, wrAddr = 0;
  logic [3:0] rdPairIdx = 0;
  logic wrEn = 0, wrWide = 0, ptrEn = 0, ptrStore = 0;
  logic [15:0] wrData = 0;
  logic [1:0] ptrSel = 0, ptrMode = 0;
  logic [5:0] ptrDisp = 0;
  logic [7:0] ptrStoreData = 0;
  logic [7:0] rdDataA, rdDataB, ptrLoadData;
  logic [15:0] rdPairData, effAddr;
  logic effIsReg, effIsIo;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] model [32];

  work_reg_bank i_work_reg_bank (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    wrEn = 0; wrWide = 0; ptrEn = 0; ptrStore = 0; ptrMode = 0; ptrSel = 0; ptrDisp = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idleInputs();
    #1;
  endtask

  task automatic compareAll(input string req);
    int errs = 0;
    for (int i = 0; i < 32; i++) begin
      rdAddrA = 5'(i); #1;
      if (rdDataA !== model[i]) begin
        errs++;
        $display("FAIL %s reg%0d actual=%h expected=%h", req, i, rdDataA, model[i]);
      end
    end
    total++;
    if (errs != 0) bad++;
  endtask

  task automatic loadPair(input int pairIdx, input logic [15:0] v);
    wrEn = 1; wrWide = 1; wrAddr = 5'(2*pairIdx); wrData = v;
    tick();
    model[2*pairIdx] = v[7:0]; model[2*pairIdx+1] = v[15:8];
  endtask

  task automatic t_reset();
    compareAll("R1");
  endtask

  task automatic t_byteWrite();
    wrEn = 1; wrAddr = 5; wrData = 16'hFFA5; tick(); model[5] = 8'hA5;
    wrEn = 1; wrAddr = 17; wrData = 16'h003C; tick(); model[17] = 8'h3C;
    rdAddrA = 5; rdAddrB = 17; #1;
    chk("R2 portA", rdDataA, 8'hA5);
    chk("R3/R2 portB", rdDataB, 8'h3C);
    compareAll("R3");
  endtask

  task automatic t_pairWrite();
    wrEn = 1; wrWide = 1; wrAddr = 9; wrData = 16'hBEEF; tick();
    model[8] = 8'hEF; model[9] = 8'hBE;
    rdPairIdx = 4; #1;
    chk("R5 pair", rdPairData, 16'hBEEF);
    rdAddrA = 8; rdAddrB = 9; #1;
    chk("R4 low", rdDataA, 8'hEF);
    chk("R4 high", rdDataB, 8'hBE);
  endtask

  task automatic t_readOld();
    rdAddrA = 5; wrEn = 1; wrAddr = 5; wrData = 16'h0011; #1;
    chk("R6 before edge", rdDataA, 8'hA5);
    tick(); model[5] = 8'h11;
    chk("R6 after edge", rdDataA, 8'h11);
  endtask

  task automatic t_postInc();
    loadPair(13, 16'h0010);
    ptrEn = 1; ptrSel = 0; ptrMode = 1; #1;
    chk("R8 addr", effAddr, 16'h0010);
    chk("R11 isReg", {15'd0, effIsReg}, 16'd1);
    tick();
    rdPairIdx = 13; #1;
    chk("R8/R7 X", rdPairData, 16'h0011);
    loadPair(15, 16'hFFFF);
    ptrEn = 1; ptrSel = 2; ptrMode = 1; tick();
    rdPairIdx = 15; #1;
    chk("R8 wrap", rdPairData, 16'h0000);
    model[26] = 8'h11; model[30] = 8'h00; model[31] = 8'h00;
  endtask

  task automatic t_preDec();
    loadPair(14, 16'h0000);
    ptrEn = 1; ptrSel = 1; ptrMode = 2; #1;
    chk("R9 addr", effAddr, 16'hFFFF);
    tick();
    rdPairIdx = 14; #1;
    chk("R9 wrap", rdPairData, 16'hFFFF);
    loadPair(14, 16'h0021);
    ptrEn = 1; ptrSel = 1; ptrMode = 2; #1;
    chk("R11 io at 0x20", {14'd0, effIsReg, effIsIo}, 16'h0001);
    tick();
    model[28] = 8'h20; model[29] = 8'h00;
    rdPairIdx = 14; #1;
    chk("R9 Y", rdPairData, 16'h0020);
  endtask

  task automatic t_offset();
    loadPair(15, 16'h0010);
    ptrEn = 1; ptrSel = 2; ptrMode = 3; ptrDisp = 6'h0F; #1;
    chk("R10 disp addr", effAddr, 16'h001F);
    chk("R11 load", {8'd0, ptrLoadData}, {8'd0, model[31]});
    tick();
    rdPairIdx = 15; #1;
    chk("R10 unchanged", rdPairData, 16'h0010);
    ptrEn = 1; ptrSel = 2; ptrMode = 3; ptrDisp = 6'h10; #1;
    chk("R11 0x20 io", {14'd0, effIsReg, effIsIo}, 16'h0001);
    loadPair(14, 16'h005F);
    ptrEn = 1; ptrSel = 1; ptrMode = 0; #1;
    chk("R10 plain", effAddr, 16'h005F);
    chk("R11 0x5F io", {14'd0, effIsReg, effIsIo}, 16'h0001);
    ptrMode = 3; ptrDisp = 1; #1;
    chk("R11 0x60 none", {14'd0, effIsReg, effIsIo}, 16'h0000);
    tick();
  endtask

  task automatic t_store();
    loadPair(13, 16'h0005);
    ptrEn = 1; ptrSel = 0; ptrMode = 0; ptrStore = 1; ptrStoreData = 8'h77; #1;
    chk("R11 load old", {8'd0, ptrLoadData}, {8'd0, model[5]});
    tick(); model[5] = 8'h77;
    compareAll("R11 store");
  endtask

  task automatic t_priority();
    ptrEn = 1; ptrSel = 0; ptrMode = 1; wrEn = 1; wrAddr = 26; wrData = 16'h0099; tick();
    model[26] = 8'h06; model[27] = 8'h00;
    rdPairIdx = 13; #1;
    chk("R12 ptr over write", rdPairData, 16'h0006);
    loadPair(13, 16'h0003);
    ptrEn = 1; ptrSel = 0; ptrMode = 0; ptrStore = 1; ptrStoreData = 8'h55;
    wrEn = 1; wrAddr = 3; wrData = 16'h0066; tick();
    model[3] = 8'h66;
    rdAddrB = 3; #1;
    chk("R12 write over store", {8'd0, rdDataB}, 16'h0066);
  endtask

  task automatic t_noSel();
    ptrEn = 1; ptrSel = 3; ptrMode = 1; ptrStore = 1; ptrStoreData = 8'hEE; #1;
    chk("R7 sel3 addr", effAddr, 16'h0000);
    chk("R7 sel3 flags", {14'd0, effIsReg, effIsIo}, 16'h0000);
    tick();
    compareAll("R7/R13 sel3 hold");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    idleInputs();
    repeat (3) @(negedge clk);
    rdAddrA = 7; #1;
    chk("R1 in reset", {8'd0, rdDataA}, 16'h0000);
    rstN = 1;
    tick();
    t_reset();
    t_byteWrite();
    t_pairWrite();
    t_readOld();
    t_postInc();
    t_preDec();
    t_offset();
    t_store();
    t_priority();
    t_noSel();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule